// File: doc/BRIEF.md
# Interrupt Source Priority Resolver

This block sits beside an instruction sequencer. At each instruction boundary it decides whether the core must enter an interrupt service sequence, and it supplies the 8-bit type number for that entry. It collects four kinds of source. The first is an exception or software-interrupt request raised by the instruction that just finished: a divide fault, a software interrupt carrying its own number, or an overflow trap. The second is an edge-triggered non-maskable pin. The third is a level-sensitive maskable request pin. The fourth is the single-step trap flag. A fixed priority picks one source per boundary. Sources that lose stay pending for a later boundary.

A maskable request has no fixed type. The block runs an acknowledge handshake with the requesting device. It raises an acknowledge output, waits for the device to mark its type byte valid, and captures that byte. Only then does it issue the take pulse. While the handshake is open, further boundary strobes are ignored. The non-maskable pin passes through a configurable number of synchronizer flops before its rising edge is detected and latched.

Top module: `intr_resolver`

## Requirements
- R1: After reset, `take_o`, `inta_o` and `type_o` are all zero and no non-maskable request is pending.
- R2: A decision is made only in a clock cycle where `boundary_i` is high and no acknowledge is open. With `boundary_i` low, no take pulse occurs and no acknowledge starts, whatever the other inputs are.
- R3: An exception request with kind code 0 (divide fault) produces type 0. Kind code 1 (software interrupt) produces the number on `exc_num_i`. In both cases `take_o` goes high in the cycle after the boundary, independent of `if_i`. Kind code 3 counts as no request.
- R4: Kind code 2 (overflow trap) produces type 4 only when `of_i` is 1. With `of_i` at 0 it raises nothing, and lower-priority sources are considered at that same boundary.
- R5: A non-maskable request becomes pending once its rising edge has passed the `NMI_SYNC_STAGES` synchronizer flops plus one edge-detect flop. It is taken as type 2 regardless of `if_i`, and taking it clears it. A pin that stays high does not raise it again.
- R6: `intr_i` is honoured only when `if_i` is 1. When it wins, `inta_o` rises in the cycle after the boundary and stays high until `ack_valid_i` is seen. In the next cycle `take_o` pulses with `type_o` equal to the captured `ack_type_i`, and `inta_o` falls.
- R7: While `inta_o` is high, `boundary_i` and every other source are ignored, and no take pulse occurs until the acknowledge completes.
- R8: With `tf_i` at 1 and no other source active, a boundary produces type 1.
- R9: The fixed priority from highest to lowest is exception, non-maskable, maskable, single-step. Only the winner is served, and a pending non-maskable request survives a boundary it loses.
- R10: `take_o` is high for exactly one cycle per decision, and `type_o` keeps its value between take pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| exc_req_i | input | 1 | Exception or software-interrupt request |
| exc_kind_i | input | 2 | 0 divide fault, 1 software interrupt, 2 overflow trap, 3 none |
| exc_num_i | input | TYPE_W | Type number of a software interrupt |
| nmi_i | input | 1 | Non-maskable pin, edge-triggered |
| intr_i | input | 1 | Maskable request pin, level-sensitive |
| if_i | input | 1 | Interrupt-enable flag |
| tf_i | input | 1 | Single-step trap flag |
| of_i | input | 1 | Overflow flag |
| ack_valid_i | input | 1 | Device type byte valid |
| ack_type_i | input | TYPE_W | Type byte from the device |
| inta_o | output | 1 | Acknowledge request to the device |
| take_o | output | 1 | Take-interrupt pulse |
| type_o | output | TYPE_W | Resolved type number |

## Verification
The bench builds the block with `TYPE_W` = 8 and `NMI_SYNC_STAGES` = 2. The 8-bit width reaches the full type range, including numbers above the fixed and reserved areas, such as 0xA5 and 0x99 from the device. The two synchronizer stages make the bench count the exact latency from a pin edge to a pending request. It then shows that a boundary arriving after that latency takes the request, and that a pin held high never raises it twice.

// File: rtl/intr_res_pkg.sv
package intr_res_pkg;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_EXC,
      SRC_NMI,
      SRC_INTR,
      SRC_STEP
   } src_e;

   typedef enum logic [1:0] {
      EXC_DIV  = 2'd0,
      EXC_SWI  = 2'd1,
      EXC_OVF  = 2'd2,
      EXC_NONE = 2'd3
   } exc_kind_e;

   typedef enum logic {
      ST_IDLE,
      ST_ACK
   } ack_st_e;

   localparam int unsigned TYPE_DIV  = 0;
   localparam int unsigned TYPE_STEP = 1;
   localparam int unsigned TYPE_NMI  = 2;
   localparam int unsigned TYPE_OVF  = 4;

endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic clr_i,
   output logic pend_o
);

   logic pin_s;
   logic pin_prev;
   logic rise;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = pin_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= pin_i;
               for (int i = 1; i < int'(SYNC_STAGES); i++) begin
                  sr[i] <= sr[i-1];
               end
            end
         end
         assign pin_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_prev <= 1'b0;
      end else begin
         pin_prev <= pin_s;
      end
   end

   assign rise = pin_s & ~pin_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
      end else begin
         pend_o <= rise | (pend_o & ~clr_i);
      end
   end

   assert_nmi_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> pend_o);
   assert_nmi_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !rise) |=> !pend_o);
   assert_nmi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !clr_i) |=> pend_o);

endmodule

// File: rtl/intr_prio_select.sv
module intr_prio_select
   import intr_res_pkg::*;
#(
   parameter int unsigned TYPE_W = 8
) (
   input  logic              exc_req_i,
   input  logic [1:0]        exc_kind_i,
   input  logic [TYPE_W-1:0] exc_num_i,
   input  logic              of_i,
   input  logic              nmi_pend_i,
   input  logic              intr_i,
   input  logic              ie_i,
   input  logic              tf_i,
   output src_e              src_o,
   output logic [TYPE_W-1:0] type_o
);

   logic              exc_live;
   logic [TYPE_W-1:0] exc_type;

   always_comb begin
      exc_live = 1'b0;
      exc_type = '0;
      if (exc_req_i) begin
         unique case (exc_kind_e'(exc_kind_i))
            EXC_DIV: begin
               exc_live = 1'b1;
               exc_type = TYPE_W'(TYPE_DIV);
            end
            EXC_SWI: begin
               exc_live = 1'b1;
               exc_type = exc_num_i;
            end
            EXC_OVF: begin
               exc_live = of_i;
               exc_type = TYPE_W'(TYPE_OVF);
            end
            default: begin
               exc_live = 1'b0;
               exc_type = '0;
            end
         endcase
      end
   end

   always_comb begin
      src_o  = SRC_NONE;
      type_o = '0;
      if (exc_live) begin
         src_o  = SRC_EXC;
         type_o = exc_type;
      end else if (nmi_pend_i) begin
         src_o  = SRC_NMI;
         type_o = TYPE_W'(TYPE_NMI);
      end else if (intr_i && ie_i) begin
         src_o  = SRC_INTR;
      end else if (tf_i) begin
         src_o  = SRC_STEP;
         type_o = TYPE_W'(TYPE_STEP);
      end
   end

endmodule

// File: rtl/intr_ack_fsm.sv
module intr_ack_fsm
   import intr_res_pkg::*;
#(
   parameter int unsigned TYPE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              decide_i,
   input  src_e              src_i,
   input  logic [TYPE_W-1:0] fixed_type_i,
   input  logic              ack_valid_i,
   input  logic [TYPE_W-1:0] ack_type_i,
   output logic              inta_o,
   output logic              take_o,
   output logic [TYPE_W-1:0] type_o,
   output logic              nmi_clr_o,
   output logic              idle_o
);

   ack_st_e state;

   assign idle_o    = (state == ST_IDLE);
   assign inta_o    = (state == ST_ACK);
   assign nmi_clr_o = idle_o && decide_i && (src_i == SRC_NMI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         take_o <= 1'b0;
         type_o <= '0;
      end else begin
         take_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (decide_i) begin
                  unique case (src_i)
                     SRC_EXC, SRC_NMI, SRC_STEP: begin
                        take_o <= 1'b1;
                        type_o <= fixed_type_i;
                     end
                     SRC_INTR: state <= ST_ACK;
                     default: ;
                  endcase
               end
            end
            ST_ACK: begin
               if (ack_valid_i) begin
                  take_o <= 1'b1;
                  type_o <= ack_type_i;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_o && !ack_valid_i) |=> inta_o);
   assert_ack_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_o && ack_valid_i) |=> (take_o && !inta_o && type_o == $past(ack_type_i)));
   assert_ack_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_o && !ack_valid_i) |=> !take_o);
   assert_no_decide_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && !decide_i) |=> (!take_o && !inta_o));
   assert_type_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> $stable(type_o) || $past(!rst_n));

endmodule

// File: rtl/intr_resolver.sv
module intr_resolver
   import intr_res_pkg::*;
#(
   parameter int unsigned TYPE_W          = 8,
   parameter int unsigned NMI_SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary_i,
   input  logic              exc_req_i,
   input  logic [1:0]        exc_kind_i,
   input  logic [TYPE_W-1:0] exc_num_i,
   input  logic              nmi_i,
   input  logic              intr_i,
   input  logic              if_i,
   input  logic              tf_i,
   input  logic              of_i,
   input  logic              ack_valid_i,
   input  logic [TYPE_W-1:0] ack_type_i,
   output logic              inta_o,
   output logic              take_o,
   output logic [TYPE_W-1:0] type_o
);

   localparam int unsigned MIN_TYPE_W = $clog2(TYPE_OVF + 1);

   generate
      if (TYPE_W < MIN_TYPE_W) begin : g_bad_width
         $error("TYPE_W too narrow for the fixed type numbers");
      end
      if (NMI_SYNC_STAGES > 8) begin : g_bad_sync
         $error("NMI_SYNC_STAGES above 8 is not supported");
      end
   endgenerate

   src_e              src;
   logic [TYPE_W-1:0] fixed_type;
   logic              nmi_pend;
   logic              nmi_clr;
   logic              idle;

   intr_nmi_latch #(
      .SYNC_STAGES(NMI_SYNC_STAGES)
   ) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (nmi_i),
      .clr_i  (nmi_clr),
      .pend_o (nmi_pend)
   );

   intr_prio_select #(
      .TYPE_W(TYPE_W)
   ) u_prio (
      .exc_req_i  (exc_req_i),
      .exc_kind_i (exc_kind_i),
      .exc_num_i  (exc_num_i),
      .of_i       (of_i),
      .nmi_pend_i (nmi_pend),
      .intr_i     (intr_i),
      .ie_i       (if_i),
      .tf_i       (tf_i),
      .src_o      (src),
      .type_o     (fixed_type)
   );

   intr_ack_fsm #(
      .TYPE_W(TYPE_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .decide_i     (boundary_i),
      .src_i        (src),
      .fixed_type_i (fixed_type),
      .ack_valid_i  (ack_valid_i),
      .ack_type_i   (ack_type_i),
      .inta_o       (inta_o),
      .take_o       (take_o),
      .type_o       (type_o),
      .nmi_clr_o    (nmi_clr),
      .idle_o       (idle)
   );

   assert_div_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && boundary_i && exc_req_i && exc_kind_i == 2'd0)
      |=> (take_o && type_o == '0));
   assert_nmi_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && boundary_i && src == SRC_NMI)
      |=> (take_o && type_o == TYPE_W'(TYPE_NMI) && !nmi_pend));
   assert_intr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !if_i) |=> !inta_o);
   assert_exc_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && boundary_i && exc_req_i && exc_kind_i == 2'd1)
      |=> (take_o && !inta_o && type_o == $past(exc_num_i)));

endmodule

// File: tb/test_intr_resolver.sv
module test_intr_resolver;

   localparam int unsigned TW   = 8;
   localparam int unsigned SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          boundary = 1'b0;
   logic          exc_req = 1'b0;
   logic [1:0]    exc_kind = 2'd3;
   logic [TW-1:0] exc_num = '0;
   logic          nmi = 1'b0;
   logic          intr = 1'b0;
   logic          ief = 1'b0;
   logic          tf = 1'b0;
   logic          of = 1'b0;
   logic          ack_valid = 1'b0;
   logic [TW-1:0] ack_type = '0;
   logic          inta;
   logic          take;
   logic [TW-1:0] typ;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   intr_resolver #(
      .TYPE_W(TW),
      .NMI_SYNC_STAGES(SYNC)
   ) i_intr_resolver (
      .clk         (clk),
      .rst_n       (rst_n),
      .boundary_i  (boundary),
      .exc_req_i   (exc_req),
      .exc_kind_i  (exc_kind),
      .exc_num_i   (exc_num),
      .nmi_i       (nmi),
      .intr_i      (intr),
      .if_i        (ief),
      .tf_i        (tf),
      .of_i        (of),
      .ack_valid_i (ack_valid),
      .ack_type_i  (ack_type),
      .inta_o      (inta),
      .take_o      (take),
      .type_o      (typ)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      boundary = 1'b0; exc_req = 1'b0; exc_kind = 2'd3; exc_num = '0;
      intr = 1'b0; ief = 1'b0; tf = 1'b0; of = 1'b0;
      ack_valid = 1'b0; ack_type = '0;
   endtask

   // one boundary pulse; outputs are sampled at the following falling edge
   task automatic pulse();
      boundary = 1'b1;
      @(negedge clk);
      boundary = 1'b0;
   endtask

   task automatic expect_take(string req, int exp_type);
      chk(req, "take", int'(take), 1);
      chk(req, "type", int'(typ), exp_type);
      chk(req, "inta", int'(inta), 0);
      @(negedge clk);
      chk("R10", "take single cycle", int'(take), 0);
      chk("R10", "type held", int'(typ), exp_type);
   endtask

   task automatic t_reset();
      chk("R1", "take", int'(take), 0);
      chk("R1", "inta", int'(inta), 0);
      chk("R1", "type", int'(typ), 0);
      tf = 1'b1;
      pulse();
      tf = 1'b0;
      chk("R1", "no pending nmi, step wins", int'(typ), 1);
      @(negedge clk);
   endtask

   task automatic t_no_boundary();
      exc_req = 1'b1; exc_kind = 2'd0; tf = 1'b1; intr = 1'b1; ief = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R2", "take without boundary", int'(take), 0);
         chk("R2", "inta without boundary", int'(inta), 0);
      end
      clear_inputs();
   endtask

   task automatic t_exceptions();
      exc_req = 1'b1; exc_kind = 2'd0; ief = 1'b0;
      pulse();
      expect_take("R3", 0);
      exc_kind = 2'd1; exc_num = 8'hA5;
      pulse();
      expect_take("R3", 'hA5);
      exc_num = 8'h03;
      pulse();
      expect_take("R3", 3);
      exc_kind = 2'd3;
      pulse();
      chk("R3", "kind 3 no take", int'(take), 0);
      clear_inputs();
   endtask

   task automatic t_overflow();
      exc_req = 1'b1; exc_kind = 2'd2; of = 1'b1;
      pulse();
      expect_take("R4", 4);
      of = 1'b0;
      pulse();
      chk("R4", "no take with of clear", int'(take), 0);
      chk("R4", "no inta with of clear", int'(inta), 0);
      tf = 1'b1;
      pulse();
      expect_take("R4", 1);
      clear_inputs();
   endtask

   task automatic t_step();
      tf = 1'b1;
      pulse();
      expect_take("R8", 1);
      clear_inputs();
   endtask

   task automatic t_nmi();
      nmi = 1'b1;
      repeat (SYNC + 1) @(negedge clk);
      ief = 1'b0;
      pulse();
      expect_take("R5", 2);
      pulse();
      chk("R5", "cleared after take", int'(take), 0);
      repeat (4) @(negedge clk);
      pulse();
      chk("R5", "held pin no retrigger", int'(take), 0);
      nmi = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      clear_inputs();
   endtask

   task automatic t_intr();
      intr = 1'b1; ief = 1'b0;
      pulse();
      chk("R6", "masked take", int'(take), 0);
      chk("R6", "masked inta", int'(inta), 0);
      ief = 1'b1;
      pulse();
      chk("R6", "inta raised", int'(inta), 1);
      chk("R6", "no take yet", int'(take), 0);
      boundary = 1'b1; exc_req = 1'b1; exc_kind = 2'd0; tf = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R7", "take blocked", int'(take), 0);
         chk("R7", "inta held", int'(inta), 1);
      end
      clear_inputs();
      ack_valid = 1'b1; ack_type = 8'h47;
      @(negedge clk);
      ack_valid = 1'b0; ack_type = 8'hFF;
      chk("R6", "take after ack", int'(take), 1);
      chk("R6", "ack type", int'(typ), 'h47);
      chk("R6", "inta dropped", int'(inta), 0);
      @(negedge clk);
      chk("R10", "ack take single", int'(take), 0);
      chk("R10", "ack type held", int'(typ), 'h47);
   endtask

   task automatic t_priority();
      nmi = 1'b1;
      repeat (SYNC + 1) @(negedge clk);
      exc_req = 1'b1; exc_kind = 2'd1; exc_num = 8'h40;
      intr = 1'b1; ief = 1'b1; tf = 1'b1;
      pulse();
      expect_take("R9", 'h40);
      exc_req = 1'b0;
      pulse();
      expect_take("R9", 2);
      pulse();
      chk("R9", "intr over step", int'(inta), 1);
      chk("R9", "no take during ack", int'(take), 0);
      ack_valid = 1'b1; ack_type = 8'h99;
      @(negedge clk);
      ack_valid = 1'b0;
      chk("R9", "device type", int'(typ), 'h99);
      chk("R9", "device take", int'(take), 1);
      intr = 1'b0;
      @(negedge clk);
      pulse();
      expect_take("R9", 1);
      nmi = 1'b0;
      clear_inputs();
      repeat (SYNC + 2) @(negedge clk);
   endtask

   initial begin : watchdog
      int cyc;
      cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_boundary();
      t_exceptions();
      t_overflow();
      t_step();
      t_nmi();
      t_intr();
      t_priority();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule